// File: doc/BRIEF.md
# Multi-Bus Slot Hotplug Register Controller

This block keeps track of hot-insert and hot-remove requests for the 32 slots on each of several buses. For every bus it stores three 32-bit masks: slots with an insertion pending, slots with a removal pending, and slots that may be removed. The system side reports insertions and removals over two event inputs. Every accepted request raises a one-cycle status event toward the firmware.

Firmware reaches the block through a 32-bit register port. It first writes a bus index into a selector register. After that, reads and eject commands apply to the selected bus. An eject write picks the lowest set bit of the data written. It drops both pending bits of that one slot and sends a one-cycle strobe that names the bus and the slot, so the platform can detach the device.

A platform reset request starts a sweep. The sweep ejects every pending removal on every bus, one slot per cycle. It then reloads the removable masks from a static per-bus mask of slots that must not be hot-plugged.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: The register offsets are: insert mask at 0x00, remove mask at 0x04, eject at 0x08, removable mask at 0x0C and bus selector at 0x10. Every read request gets `rd_valid` one cycle later, with the data in `rd_data`. A read of the eject offset returns 0. A read of the selector returns the last value written to it.
- R2: An access acts only when `acc_be` is 4'b1111 and `acc_addr[1:0]` is 0. Any other access is ignored. If it is a read, it returns 0.
- R3: A plug request with `plug_hot`=1 on a bus below NUM_BUS sets that slot's insert bit. `hp_event` is high in the next cycle. A plug request with `plug_hot`=0 (a device already present at start-up) changes no mask and raises no event.
- R4: An unplug request on a bus below NUM_BUS sets that slot's remove bit, and `hp_event` is high in the next cycle.
- R5: With `legacy_mode`=0, reading the insert mask clears it. With `legacy_mode`=1, the mask is left unchanged.
- R6: An eject write acts on the lowest set bit of `acc_wdata` only. It clears that slot's insert and remove bits on the selected bus. In the next cycle, `ej_valid` pulses for one cycle with `ej_bus`/`ej_slot`. Written data of zero has no effect.
- R7: If the selector holds a value of NUM_BUS or more, every read returns 0 and eject writes do nothing.
- R8: With `legacy_mode`=1, offset 0x10 lies outside the window. Its reads return 0 and its writes leave the selector unchanged.
- R9: `rst` clears all pending masks and sets the selector to 0. It loads each removable mask with the inverse of that bus's slice of `nohp_mask`. A `soft_rst` pulse ejects every pending removal, one per cycle, starting at bus 0 and the lowest slot, with one strobe each. It then reloads the removable masks from the current `nohp_mask`. Outside these two cases the removable masks hold their value.
- R10: If a set and a clear of the same insert bit land in the same cycle (a plug together with an insert read-clear, or a plug together with an eject of that slot), the bit ends up set.
- R11: Plug or unplug requests naming a bus at or above NUM_BUS are ignored and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | One-cycle request to start the removal sweep |
| legacy_mode | input | 1 | Keeps insert mask on read; shrinks window to 0x00-0x0C |
| nohp_mask | input | 32*NUM_BUS | Per-bus slots that must not be hot-plugged (bus b at bits 32b+31:32b) |
| plug_valid | input | 1 | Insert request |
| plug_hot | input | 1 | 1: hot-added device, 0: device present at start-up |
| plug_bus | input | 8 | Bus of the insert request |
| plug_slot | input | 5 | Slot of the insert request |
| unplug_valid | input | 1 | Removal request |
| unplug_bus | input | 8 | Bus of the removal request |
| unplug_slot | input | 5 | Slot of the removal request |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1: write, 0: read |
| acc_addr | input | 5 | Byte offset |
| acc_be | input | 4 | Byte enables |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| hp_event | output | 1 | Status event pulse |
| ej_valid | output | 1 | Eject strobe |
| ej_bus | output | 8 | Bus of the ejected slot |
| ej_slot | output | 5 | Ejected slot |

## Verification
The checker assumes that a register access and a sweep never overlap in a way that would make a firmware eject look like a sweep eject. The bench therefore leaves the register port idle until a sweep has run its full length. The checker also assumes that `nohp_mask` and `legacy_mode` change only while the block is idle, and the bench changes them only between operations. Same-cycle collisions are produced on purpose, and only on the insert mask of the selected bus, where R10 defines the result.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int SLOTS  = 32;
    localparam int SLOT_W = 5;
    localparam int DW     = 32;
    localparam int AW     = 5;
    localparam int BID_W  = 8;

    typedef enum logic [AW-1:0] {
        OFF_INS = 5'h00,
        OFF_REM = 5'h04,
        OFF_EJ  = 5'h08,
        OFF_ENA = 5'h0C,
        OFF_SEL = 5'h10
    } hp_reg_e;

    typedef enum logic {SW_IDLE, SW_SCAN} sweep_state_e;

    typedef struct packed {
        logic              vld;
        logic [BID_W-1:0]  bus;
        logic [SLOT_W-1:0] slot;
    } slot_ref_t;

    function automatic logic [SLOT_W-1:0] lowest_slot(input logic [SLOTS-1:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (m[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    function automatic logic [SLOTS-1:0] slot_bit(input logic [SLOT_W-1:0] s);
        return SLOTS'(1) << s;
    endfunction
endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] set_ins,
    input  logic [SLOTS-1:0] set_rem,
    input  logic [SLOTS-1:0] clr_slot,
    input  logic             clr_all_ins,
    input  logic             ena_load,
    input  logic [SLOTS-1:0] nohp,
    output logic [SLOTS-1:0] ins_q,
    output logic [SLOTS-1:0] rem_q,
    output logic [SLOTS-1:0] ena_q
);
    logic [SLOTS-1:0] ins_keep;

    // clears first, then sets: a new request always survives
    always_comb begin
        ins_keep = ins_q & ~clr_slot;
        if (clr_all_ins) ins_keep = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= '0;
            rem_q <= '0;
            ena_q <= ~nohp;
        end else begin
            ins_q <= ins_keep | set_ins;
            rem_q <= (rem_q & ~clr_slot) | set_rem;
            if (ena_load) ena_q <= ~nohp;
        end
    end
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SLOTS-1:0] rem_cur,
    output logic             busy,
    output logic [BID_W-1:0] bus_idx,
    output slot_ref_t        ej_cmd,
    output logic             ena_load
);
    localparam logic [BID_W-1:0] LAST_BUS = BID_W'(NUM_BUS - 1);

    sweep_state_e state_q;
    logic         bus_clear;

    assign busy      = (state_q == SW_SCAN);
    assign bus_clear = (rem_cur == '0);
    assign ena_load  = busy && bus_clear && (bus_idx == LAST_BUS);

    always_comb begin
        ej_cmd.vld  = busy && !bus_clear;
        ej_cmd.bus  = bus_idx;
        ej_cmd.slot = lowest_slot(rem_cur);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            bus_idx <= '0;
        end else begin
            case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        state_q <= SW_SCAN;
                        bus_idx <= '0;
                    end
                end
                default: begin
                    if (bus_clear) begin
                        if (bus_idx == LAST_BUS) state_q <= SW_IDLE;
                        else                     bus_idx <= bus_idx + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hp_regif.sv
module hp_regif
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          legacy,
    input  logic          busy,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [3:0]    acc_be,
    input  logic [DW-1:0] acc_wdata,
    input  logic [DW-1:0] cur_ins,
    input  logic [DW-1:0] cur_rem,
    input  logic [DW-1:0] cur_ena,
    output logic [DW-1:0] sel_q,
    output logic          sel_ok,
    output logic          clr_ins,
    output slot_ref_t     ej_cmd,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0] win_top;
    logic          hit;
    logic          rd_hit;
    logic          wr_hit;
    logic [DW-1:0] rd_word;

    assign win_top = legacy ? OFF_ENA : OFF_SEL;
    assign hit     = acc_valid && !busy && (acc_be == 4'hF) &&
                     (acc_addr[1:0] == 2'b00) && (acc_addr <= win_top);
    assign rd_hit  = hit && !acc_write;
    assign wr_hit  = hit && acc_write;
    assign sel_ok  = (sel_q < DW'(NUM_BUS));

    always_comb begin
        case (acc_addr)
            OFF_INS: rd_word = cur_ins;
            OFF_REM: rd_word = cur_rem;
            OFF_ENA: rd_word = cur_ena;
            OFF_SEL: rd_word = sel_q;
            default: rd_word = '0;
        endcase
    end

    assign clr_ins = rd_hit && sel_ok && !legacy && (acc_addr == OFF_INS);

    always_comb begin
        ej_cmd.vld  = wr_hit && sel_ok && (acc_addr == OFF_EJ) && (acc_wdata != '0);
        ej_cmd.bus  = sel_q[BID_W-1:0];
        ej_cmd.slot = lowest_slot(acc_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_valid && !acc_write;
            rd_data  <= (rd_hit && sel_ok) ? rd_word : '0;
            if (wr_hit && (acc_addr == OFF_SEL)) sel_q <= acc_wdata;
        end
    end
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     soft_rst,
    input  logic                     legacy_mode,
    input  logic [NUM_BUS*SLOTS-1:0] nohp_mask,
    input  logic                     plug_valid,
    input  logic                     plug_hot,
    input  logic [BID_W-1:0]         plug_bus,
    input  logic [SLOT_W-1:0]        plug_slot,
    input  logic                     unplug_valid,
    input  logic [BID_W-1:0]         unplug_bus,
    input  logic [SLOT_W-1:0]        unplug_slot,
    input  logic                     acc_valid,
    input  logic                     acc_write,
    input  logic [AW-1:0]            acc_addr,
    input  logic [3:0]               acc_be,
    input  logic [DW-1:0]            acc_wdata,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data,
    output logic                     hp_event,
    output logic                     ej_valid,
    output logic [BID_W-1:0]         ej_bus,
    output logic [SLOT_W-1:0]        ej_slot
);
    localparam int BSW = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
    localparam logic [BID_W-1:0] BUS_LIM = BID_W'(NUM_BUS);

    logic [SLOTS-1:0] ins_q [NUM_BUS];
    logic [SLOTS-1:0] rem_q [NUM_BUS];
    logic [SLOTS-1:0] ena_q [NUM_BUS];

    logic             plug_ok, unplug_ok;
    logic [DW-1:0]    sel_q;
    logic             sel_ok, reg_clr;
    logic [DW-1:0]    cur_ins, cur_rem, cur_ena;
    slot_ref_t        reg_ej, sw_ej, ej;
    logic             sw_busy, sw_ena_load;
    logic [BID_W-1:0] sw_idx;
    logic [SLOTS-1:0] sw_rem;

    assign plug_ok   = plug_valid && plug_hot && (plug_bus < BUS_LIM);
    assign unplug_ok = unplug_valid && (unplug_bus < BUS_LIM);

    always_comb begin
        cur_ins = '0;
        cur_rem = '0;
        cur_ena = '0;
        if (sel_ok) begin
            cur_ins = ins_q[sel_q[BSW-1:0]];
            cur_rem = rem_q[sel_q[BSW-1:0]];
            cur_ena = ena_q[sel_q[BSW-1:0]];
        end
    end

    assign sw_rem = rem_q[sw_idx[BSW-1:0]];
    assign ej     = sw_busy ? sw_ej : reg_ej;

    hp_regif #(.NUM_BUS(NUM_BUS)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .legacy    (legacy_mode),
        .busy      (sw_busy),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_be    (acc_be),
        .acc_wdata (acc_wdata),
        .cur_ins   (cur_ins),
        .cur_rem   (cur_rem),
        .cur_ena   (cur_ena),
        .sel_q     (sel_q),
        .sel_ok    (sel_ok),
        .clr_ins   (reg_clr),
        .ej_cmd    (reg_ej),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    hp_sweep #(.NUM_BUS(NUM_BUS)) u_sweep (
        .clk      (clk),
        .rst      (rst),
        .start    (soft_rst),
        .rem_cur  (sw_rem),
        .busy     (sw_busy),
        .bus_idx  (sw_idx),
        .ej_cmd   (sw_ej),
        .ena_load (sw_ena_load)
    );

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        localparam logic [BID_W-1:0] BID = BID_W'(b);
        logic [SLOTS-1:0] set_ins, set_rem, clr_slot;
        logic             clr_all;

        assign set_ins  = (plug_ok && plug_bus == BID) ? slot_bit(plug_slot) : '0;
        assign set_rem  = (unplug_ok && unplug_bus == BID) ? slot_bit(unplug_slot) : '0;
        assign clr_slot = (ej.vld && ej.bus == BID) ? slot_bit(ej.slot) : '0;
        assign clr_all  = reg_clr && (sel_q == DW'(b));

        hp_slot_bank u_bank (
            .clk         (clk),
            .rst         (rst),
            .set_ins     (set_ins),
            .set_rem     (set_rem),
            .clr_slot    (clr_slot),
            .clr_all_ins (clr_all),
            .ena_load    (sw_ena_load),
            .nohp        (nohp_mask[b*SLOTS +: SLOTS]),
            .ins_q       (ins_q[b]),
            .rem_q       (rem_q[b]),
            .ena_q       (ena_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_event <= 1'b0;
            ej_valid <= 1'b0;
            ej_bus   <= '0;
            ej_slot  <= '0;
        end else begin
            hp_event <= plug_ok || unplug_ok;
            ej_valid <= ej.vld;
            ej_bus   <= ej.bus;
            ej_slot  <= ej.slot;
        end
    end
endmodule

// File: rtl/slot_hotplug_ctrl_chk.sv
module slot_hotplug_ctrl_chk
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              legacy_mode,
    input logic              plug_valid,
    input logic              plug_hot,
    input logic [BID_W-1:0]  plug_bus,
    input logic              unplug_valid,
    input logic [BID_W-1:0]  unplug_bus,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [AW-1:0]     acc_addr,
    input logic [3:0]        acc_be,
    input logic [DW-1:0]     acc_wdata,
    input logic              sw_busy,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data,
    input logic              hp_event,
    input logic              ej_valid,
    input logic [BID_W-1:0]  ej_bus
);
    localparam logic [BID_W-1:0] LIM = BID_W'(NUM_BUS);

    logic hot_in, rem_in, ej_wr;
    assign hot_in = plug_valid && plug_hot && (plug_bus < LIM);
    assign rem_in = unplug_valid && (unplug_bus < LIM);
    assign ej_wr  = acc_valid && acc_write && (acc_addr == OFF_EJ);

    AST_RD_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write |=> rd_valid); // R1
    AST_EJ_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_addr == OFF_EJ |=> rd_data == '0); // R1
    AST_BAD_SIZE_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_be != 4'hF |=> rd_valid && rd_data == '0); // R2
    AST_HOT_PLUG_EVENT: assert property (@(posedge clk) disable iff (rst)
        hot_in |=> hp_event); // R3
    AST_UNPLUG_EVENT: assert property (@(posedge clk) disable iff (rst)
        rem_in |=> hp_event); // R4
    AST_NO_EVENT_UNCAUSED: assert property (@(posedge clk) disable iff (rst)
        !hot_in && !rem_in |=> !hp_event); // R11
    AST_ZERO_EJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        ej_wr && acc_wdata == '0 && !sw_busy |=> !ej_valid); // R6
    AST_EJ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !sw_busy && !ej_wr |=> !ej_valid); // R6
    AST_EJ_BUS_RANGE: assert property (@(posedge clk) disable iff (rst)
        ej_valid |-> ej_bus < LIM); // R7
    AST_LEGACY_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && legacy_mode && acc_addr == OFF_SEL |=> rd_data == '0); // R8
endmodule

bind slot_hotplug_ctrl slot_hotplug_ctrl_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .legacy_mode  (legacy_mode),
    .plug_valid   (plug_valid),
    .plug_hot     (plug_hot),
    .plug_bus     (plug_bus),
    .unplug_valid (unplug_valid),
    .unplug_bus   (unplug_bus),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_be       (acc_be),
    .acc_wdata    (acc_wdata),
    .sw_busy      (sw_busy),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .hp_event     (hp_event),
    .ej_valid     (ej_valid),
    .ej_bus       (ej_bus)
);

// File: tb/slot_hotplug_ctrl_test.sv
`timescale 1ns/1ps
module slot_hotplug_ctrl_test;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          soft_rst = 1'b0;
    logic          legacy_mode = 1'b0;
    logic [NB*32-1:0] nohp_mask;
    logic          plug_valid = 1'b0, plug_hot = 1'b0;
    logic [7:0]    plug_bus = '0;
    logic [4:0]    plug_slot = '0;
    logic          unplug_valid = 1'b0;
    logic [7:0]    unplug_bus = '0;
    logic [4:0]    unplug_slot = '0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [4:0]    acc_addr = '0;
    logic [3:0]    acc_be = '0;
    logic [31:0]   acc_wdata = '0;
    logic          rd_valid, hp_event, ej_valid;
    logic [31:0]   rd_data;
    logic [7:0]    ej_bus;
    logic [4:0]    ej_slot;

    slot_hotplug_ctrl #(.NUM_BUS(NB)) uut (.*);

    always #10 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] rd_q[$];  string rd_t[$];
    logic [12:0] ej_q[$];  string ej_t[$];
    string       ev_t[$];

    logic [31:0] m_ins[NB], m_rem[NB], m_ena[NB], m_sel;
    bit          m_leg;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid) begin
                if (rd_q.size() == 0) chk(0, "R1 unexpected read", rd_data, 32'hx);
                else begin
                    logic [31:0] e; string t;
                    e = rd_q.pop_front(); t = rd_t.pop_front();
                    chk(rd_data === e, t, rd_data, e);
                end
            end
            if (ej_valid) begin
                if (ej_q.size() == 0) chk(0, "R6 unexpected eject", {19'd0, ej_bus, ej_slot}, 32'hx);
                else begin
                    logic [12:0] e; string t;
                    e = ej_q.pop_front(); t = ej_t.pop_front();
                    chk({ej_bus, ej_slot} === e, t, {19'd0, ej_bus, ej_slot}, {19'd0, e});
                end
            end
            if (hp_event) begin
                if (ev_t.size() == 0) chk(0, "R11 unexpected event", 32'd1, 32'd0);
                else begin
                    string t;
                    t = ev_t.pop_front();
                    chk(1, t, 32'd1, 32'd1);
                end
            end
        end
    end

    function automatic bit m_hit(input logic [4:0] a, input logic [3:0] be);
        return be == 4'hF && a[1:0] == 2'b00 && a <= (m_leg ? 5'h0C : 5'h10);
    endfunction

    task automatic m_read(input logic [4:0] a, input logic [3:0] be, input string tag);
        logic [31:0] e;
        e = '0;
        if (m_hit(a, be) && m_sel < NB) begin
            case (a)
                5'h00: e = m_ins[m_sel];
                5'h04: e = m_rem[m_sel];
                5'h0C: e = m_ena[m_sel];
                5'h10: e = m_sel;
                default: e = '0;
            endcase
            if (a == 5'h00 && !m_leg) m_ins[m_sel] = '0;
        end
        rd_q.push_back(e); rd_t.push_back(tag);
    endtask

    task automatic m_write(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
        if (m_hit(a, be)) begin
            if (a == 5'h10) m_sel = d;
            if (a == 5'h08 && m_sel < NB && d != 0) begin
                int s; s = 0;
                for (int i = 31; i >= 0; i--) if (d[i]) s = i;
                m_ins[m_sel][s] = 1'b0;
                m_rem[m_sel][s] = 1'b0;
                ej_q.push_back({m_sel[7:0], 5'(s)}); ej_t.push_back(tag);
            end
        end
    endtask

    task automatic m_plug(input logic [7:0] b, input logic [4:0] s, input bit hot, input string tag);
        if (hot && b < NB) begin
            m_ins[b][s] = 1'b1;
            ev_t.push_back(tag);
        end
    endtask

    task automatic m_unplug(input logic [7:0] b, input logic [4:0] s, input string tag);
        if (b < NB) begin
            m_rem[b][s] = 1'b1;
            ev_t.push_back(tag);
        end
    endtask

    task automatic clear_in();
        plug_valid = 0; plug_hot = 0; unplug_valid = 0;
        acc_valid = 0; acc_write = 0; acc_be = 0; acc_addr = 0; acc_wdata = 0;
    endtask

    task automatic set_acc(input bit w, input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        acc_valid = 1; acc_write = w; acc_addr = a; acc_be = be; acc_wdata = d;
    endtask

    task automatic rd(input logic [4:0] a, input logic [3:0] be, input string tag);
        @(negedge clk); m_read(a, be, tag); set_acc(0, a, be, 0);
        @(negedge clk); clear_in();
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d, input string tag);
        @(negedge clk); m_write(a, be, d, tag); set_acc(1, a, be, d);
        @(negedge clk); clear_in();
    endtask

    task automatic plug(input logic [7:0] b, input logic [4:0] s, input bit hot, input string tag);
        @(negedge clk); m_plug(b, s, hot, tag);
        plug_valid = 1; plug_hot = hot; plug_bus = b; plug_slot = s;
        @(negedge clk); clear_in();
    endtask

    task automatic unplug(input logic [7:0] b, input logic [4:0] s, input string tag);
        @(negedge clk); m_unplug(b, s, tag);
        unplug_valid = 1; unplug_bus = b; unplug_slot = s;
        @(negedge clk); clear_in();
    endtask

    task automatic sweep(input string tag);
        int n; n = 0;
        for (int b = 0; b < NB; b++)
            for (int s = 0; s < 32; s++)
                if (m_rem[b][s]) begin
                    ej_q.push_back({8'(b), 5'(s)}); ej_t.push_back(tag);
                    m_ins[b][s] = 0; m_rem[b][s] = 0; n++;
                end
        for (int b = 0; b < NB; b++) m_ena[b] = ~nohp_mask[b*32 +: 32];
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        repeat (n + NB + 3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        nohp_mask = {32'hFFFF_0000, 32'h0, 32'h8000_0000, 32'h0000_0003};
        for (int b = 0; b < NB; b++) begin
            m_ins[b] = 0; m_rem[b] = 0; m_ena[b] = ~nohp_mask[b*32 +: 32];
        end
        m_sel = 0; m_leg = 0;
        repeat (5) @(negedge clk);
        rst = 0;

        // reset state
        rd(5'h00, 4'hF, "R9 reset insert mask");
        rd(5'h04, 4'hF, "R9 reset remove mask");
        rd(5'h0C, 4'hF, "R9 reset removable mask");
        rd(5'h10, 4'hF, "R9 reset selector");

        // hot insert, read-clear
        plug(0, 5, 1, "R3 event slot5");
        plug(0, 9, 1, "R3 event slot9");
        rd(5'h00, 4'hF, "R3 insert mask bus0");
        rd(5'h00, 4'hF, "R5 insert cleared by read");
        plug(0, 3, 0, "R3 cold plug");
        rd(5'h00, 4'hF, "R3 cold plug leaves mask");

        // remove and eject on bus 1
        unplug(1, 7, "R4 event slot7");
        unplug(1, 2, "R4 event slot2");
        plug(1, 7, 1, "R3 event bus1 slot7");
        plug(1, 2, 1, "R3 event bus1 slot2");
        wr(5'h10, 4'hF, 1, "R1 select");
        rd(5'h10, 4'hF, "R1 selector readback");
        rd(5'h04, 4'hF, "R4 remove mask bus1");
        wr(5'h08, 4'hF, 32'h0000_0084, "R6 eject lowest slot");
        rd(5'h04, 4'hF, "R6 remove after eject");
        rd(5'h00, 4'hF, "R6 insert after eject");
        wr(5'h08, 4'hF, 0, "R6 zero eject");
        rd(5'h04, 4'hF, "R6 zero eject no effect");
        rd(5'h08, 4'hF, "R1 eject reads zero");
        rd(5'h0C, 4'hF, "R1 removable mask bus1");

        // size and alignment
        rd(5'h04, 4'h3, "R2 partial read zero");
        wr(5'h10, 4'h3, 2, "R2 partial write");
        rd(5'h10, 4'hF, "R2 selector unchanged");
        rd(5'h05, 4'hF, "R2 misaligned read zero");

        // out-of-range selector
        wr(5'h10, 4'hF, 4, "R7 select out of range");
        rd(5'h04, 4'hF, "R7 remove reads zero");
        rd(5'h10, 4'hF, "R7 selector reads zero");
        wr(5'h08, 4'hF, 32'h80, "R7 eject ignored");
        wr(5'h10, 4'hF, 1, "R7 reselect");
        rd(5'h04, 4'hF, "R7 remove kept");

        // out-of-range event bus
        plug(9, 1, 1, "R11 plug bus9");
        unplug(8'd5, 1, "R11 unplug bus5");
        rd(5'h00, 4'hF, "R11 bus1 untouched");
        rd(5'h04, 4'hF, "R11 bus1 remove untouched");

        // same-cycle collisions
        wr(5'h10, 4'hF, 2, "R10 select bus2");
        plug(2, 4, 1, "R10 event slot4");
        @(negedge clk);
        m_read(5'h00, 4'hF, "R10 read with concurrent plug");
        m_plug(2, 11, 1, "R10 event slot11");
        set_acc(0, 5'h00, 4'hF, 0);
        plug_valid = 1; plug_hot = 1; plug_bus = 2; plug_slot = 11;
        @(negedge clk); clear_in();
        rd(5'h00, 4'hF, "R10 new insert survives read-clear");
        unplug(2, 6, "R10 event unplug slot6");
        @(negedge clk);
        m_write(5'h08, 4'hF, 32'h40, "R10 eject slot6");
        m_plug(2, 6, 1, "R10 event plug slot6");
        set_acc(1, 5'h08, 4'hF, 32'h40);
        plug_valid = 1; plug_hot = 1; plug_bus = 2; plug_slot = 6;
        @(negedge clk); clear_in();
        rd(5'h04, 4'hF, "R10 remove cleared by eject");
        rd(5'h00, 4'hF, "R10 insert survives eject");

        // legacy mode
        plug(2, 6, 1, "R5 event slot6");
        @(negedge clk); legacy_mode = 1; m_leg = 1;
        rd(5'h00, 4'hF, "R5 legacy read");
        rd(5'h00, 4'hF, "R5 legacy mask kept");
        wr(5'h10, 4'hF, 0, "R8 legacy select write");
        rd(5'h10, 4'hF, "R8 legacy selector reads zero");
        rd(5'h00, 4'hF, "R8 selector unchanged in legacy");
        @(negedge clk); legacy_mode = 0; m_leg = 0;

        // sweep
        unplug(0, 30, "R9 event bus0 slot30");
        unplug(0, 3, "R9 event bus0 slot3");
        unplug(3, 0, "R9 event bus3 slot0");
        plug(3, 0, 1, "R9 event plug bus3 slot0");
        @(negedge clk); nohp_mask[3*32 +: 32] = 32'h0000_00F0;
        wr(5'h10, 4'hF, 3, "R9 select bus3");
        rd(5'h0C, 4'hF, "R9 removable mask held");
        m_ena[3] = ~32'h0000_00F0;
        sweep("R9 sweep eject");
        rd(5'h00, 4'hF, "R9 insert cleared by sweep");
        rd(5'h04, 4'hF, "R9 remove cleared by sweep");
        rd(5'h0C, 4'hF, "R9 removable reloaded");
        wr(5'h10, 4'hF, 0, "R9 select bus0");
        rd(5'h04, 4'hF, "R9 bus0 remove cleared");

        repeat (4) @(negedge clk);
        chk(rd_q.size() == 0, "R1 reads outstanding", rd_q.size(), 0);
        chk(ej_q.size() == 0, "R6 ejects outstanding", ej_q.size(), 0);
        chk(ev_t.size() == 0, "R3 events outstanding", ev_t.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule